// File: doc/BRIEF.md
# Stochastic Bitstream Dot-Product Unit

This block computes the dot product of several unsigned 8-bit fractions with 8-bit unsigned weights, using stochastic arithmetic. Every operand is turned into a serial bit stream whose density of ones equals the operand divided by 256. For each lane, the activation stream and the weight stream are combined with a single AND gate. A binary accumulator then counts the product ones of all lanes over one full stream period of 256 cycles.

The two streams come from one deterministic sequence generator that all lanes share. Activation bits compare the operand with an ascending cycle index. Weight bits compare the operand with the bit-reversed index, which is the base-2 low-discrepancy sequence. Because the two comparison orders differ, the inputs of each AND gate are uncorrelated.

The accumulator counts ones and does not OR the streams together, so the result never saturates. A start pulse captures both operand vectors and runs the stream. Busy stays high during the run. A one-cycle done pulse marks the result, and the count is then held until the next accepted start. There is no back-pressure: the caller reads the count at any time after done and before it issues the next start.

Top module: `sc_dot_mac`

## Requirements
- R1: After reset, busy, done and count are all 0.
- R2: The activation stream of a lane at run cycle t (t = 0..255, counting from the first cycle after start) is 1 exactly when the activation is greater than t.
- R3: The weight stream of a lane at run cycle t is 1 exactly when the weight is greater than rev(t), where rev reverses the 8 bits of t (bit 0 becomes bit 7).
- R4: At done, the count equals the number of (lane, t) pairs over all lanes and t = 0..255 where both stream bits are 1. The accumulator is wide enough for LANES × 256; all operands at 255 give LANES × 255.
- R5: A lane whose activation or weight is 0 contributes nothing to the count.
- R6: Done is high for exactly one cycle, 256 clock edges after the edge that accepted start. Busy is high from the edge after that start until done rises.
- R7: The count is cleared when a start is accepted. It stays unchanged from done until the next accepted start, whatever the operand inputs do.
- R8: Start is ignored while busy. Operands are captured at the accepted start, so later changes on the operand inputs have no effect on the run.
- R9: For every lane, the count differs from the exact product activation × weight / 256 by no more than 8, summed over the lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only when not busy |
| act_i | input | LANES*8 | Activations, lane k in bits [8k+7:8k] |
| wgt_i | input | LANES*8 | Weights, lane k in bits [8k+7:8k] |
| busy_o | output | 1 | Stream run in progress |
| done_o | output | 1 | One-cycle pulse marking a valid count |
| count_o | output | $clog2(LANES*256+1) | Accumulated ones count |

## Verification
The result is due at the negative edge that follows the 256th rising edge after the edge that accepted start. The bench counts rising edges from that start edge and requires done to appear at exactly that count. It samples busy, done and count only at negative edges, so no value is read while the clock edge is updating it. It also checks that done falls on the next cycle. The stability check waits 20 further cycles with new operand values on the inputs and then compares the count with the value it had at done.

// File: rtl/sc_mac_pkg.sv
package sc_mac_pkg;
  typedef enum logic {
    MAC_IDLE = 1'b0,
    MAC_RUN  = 1'b1
  } mac_state_e;
endpackage

// File: rtl/sc_vdc_seq.sv
module sc_vdc_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  output logic [W-1:0] idx_o,
  output logic [W-1:0] rev_o,
  output logic         last_o
);
  localparam logic [W-1:0] IDX_MAX = {W{1'b1}};

  logic [W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (run_i) idx_q <= idx_q + 1'b1;
  end

  for (genvar b = 0; b < W; b++) begin : g_rev
    assign rev_o[b] = idx_q[W-1-b];
  end

  assign idx_o  = idx_q;
  assign last_o = run_i && (idx_q == IDX_MAX);

  // R2: the index wraps to zero after the final stream cycle
  assert_seq_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && idx_q == IDX_MAX) |=> (idx_q == '0));
endmodule

// File: rtl/sc_prod_lane.sv
module sc_prod_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] act_i,
  input  logic [W-1:0] wgt_i,
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] rev_i,
  output logic         prod_o
);
  logic act_bit;
  logic wgt_bit;

  assign act_bit = act_i > idx_i;
  assign wgt_bit = wgt_i > rev_i;
  assign prod_o  = act_bit & wgt_bit;

  always_comb begin
    // R5: a zero operand never produces a product one
    if (act_i == '0 || wgt_i == '0) begin
      assert_zero_lane_R5: assert (prod_o == 1'b0);
    end
  end
endmodule

// File: rtl/sc_ones_acc.sv
module sc_ones_acc #(
  parameter int LANES = 4,
  parameter int CW    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [LANES-1:0] bits_i,
  output logic [CW-1:0]    sum_o
);
  localparam int PW = $clog2(LANES + 1);

  logic [PW-1:0] pop;
  logic [CW-1:0] sum_q;
  logic [CW:0]   sum_nxt;

  always_comb begin
    pop = '0;
    for (int k = 0; k < LANES; k++) begin
      pop = pop + PW'(bits_i[k]);
    end
  end

  assign sum_nxt = {1'b0, sum_q} + (CW+1)'(pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (en_i)  sum_q <= sum_nxt[CW-1:0];
  end

  assign sum_o = sum_q;

  // R4: accumulation never wraps
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (sum_nxt[CW] == 1'b0));
endmodule

// File: rtl/sc_dot_mac.sv
module sc_dot_mac
  import sc_mac_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 8,
  localparam int CW   = $clog2(LANES * (1 << W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [LANES*W-1:0] act_i,
  input  logic [LANES*W-1:0] wgt_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CW-1:0]      count_o
);
  mac_state_e         state_q;
  logic               done_q;
  logic [LANES*W-1:0] act_q;
  logic [LANES*W-1:0] wgt_q;
  logic               go;
  logic               running;
  logic               last;
  logic [W-1:0]       idx;
  logic [W-1:0]       rev;
  logic [LANES-1:0]   prod;

  assign running = (state_q == MAC_RUN);
  assign go      = start_i && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MAC_IDLE;
      done_q  <= 1'b0;
      act_q   <= '0;
      wgt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        state_q <= MAC_RUN;
        act_q   <= act_i;
        wgt_q   <= wgt_i;
      end else if (last) begin
        state_q <= MAC_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  sc_vdc_seq #(.W(W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (go),
    .run_i  (running),
    .idx_o  (idx),
    .rev_o  (rev),
    .last_o (last)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sc_prod_lane #(.W(W)) u_lane (
      .act_i  (act_q[k*W +: W]),
      .wgt_i  (wgt_q[k*W +: W]),
      .idx_i  (idx),
      .rev_i  (rev),
      .prod_o (prod[k])
    );
  end

  sc_ones_acc #(.LANES(LANES), .CW(CW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (go),
    .en_i   (running),
    .bits_i (prod),
    .sum_o  (count_o)
  );

  assign busy_o = running;
  assign done_o = done_q;

  // R6: done lasts a single cycle and never overlaps busy
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !running);
  // R7: the held result only changes when a start is accepted
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_i) |=> $stable(count_o));
  // R8: a start during a run neither restarts it nor reloads operands
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_i && !last) |=> (running && $stable(act_q) && $stable(wgt_q)));
endmodule

// File: tb/test_sc_dot_mac.sv
`timescale 1ns/1ps
module test_sc_dot_mac;
  localparam int LANES = 4;
  localparam int W     = 8;
  localparam int CW    = $clog2(LANES * (1 << W) + 1);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [LANES*W-1:0] act_i = '0;
  logic [LANES*W-1:0] wgt_i = '0;
  logic               busy_o;
  logic               done_o;
  logic [CW-1:0]      count_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sc_dot_mac #(.LANES(LANES), .W(W)) i_sc_dot_mac (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .act_i(act_i), .wgt_i(wgt_i),
    .busy_o(busy_o), .done_o(done_o), .count_o(count_o)
  );

  function automatic int rev8(int t);
    int r = 0;
    for (int b = 0; b < 8; b++) if (t[b]) r |= (1 << (7 - b));
    return r;
  endfunction

  // expected count per R2, R3, R4
  function automatic int lane_ref(int a, int w);
    int c = 0;
    for (int t = 0; t < 256; t++) if (a > t && w > rev8(t)) c++;
    return c;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one product; returns count, checks R6 timing
  task automatic run(input int a[LANES], input int w[LANES], output int res);
    int n = 0;
    @(negedge clk);
    for (int k = 0; k < LANES; k++) begin
      act_i[k*W +: W] = W'(a[k]);
      wgt_i[k*W +: W] = W'(w[k]);
    end
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    check("R6 done latency", n, 256);
    res = count_o;
    @(negedge clk);
    check("R6 done one cycle", int'(done_o), 0);
  endtask

  task automatic full_check(input int a[LANES], input int w[LANES]);
    int res, exp, ideal;
    run(a, w, res);
    exp = 0; ideal = 0;
    for (int k = 0; k < LANES; k++) begin
      exp += lane_ref(a[k], w[k]);
      ideal += a[k] * w[k];
    end
    check("R4 count", res, exp);
    ideal = ideal / 256;
    tests++;
    if (res - ideal > 8 * LANES || ideal - res > 8 * LANES) begin
      fails++;
      $display("FAIL R9 bound: actual %0d expected %0d +/- %0d", res, ideal, 8 * LANES);
    end
  endtask

  initial begin
    int a[LANES], w[LANES];
    int res, held;
    #1;
    check("R1 busy at reset", int'(busy_o), 0);
    check("R1 done at reset", int'(done_o), 0);
    check("R1 count at reset", int'(count_o), 0);
    #10 rst_n = 1'b1;

    // R4: all-ones operands
    for (int k = 0; k < LANES; k++) begin a[k] = 255; w[k] = 255; end
    run(a, w, res);
    check("R4 all max", res, LANES * 255);

    // R5: zero operands in different lanes
    a = '{0, 200, 77, 255}; w = '{255, 0, 0, 0};
    run(a, w, res);
    check("R5 zero lanes", res, 0);

    // R2/R3: single-lane probes of the stream encodings
    a = '{1, 0, 0, 0}; w = '{1, 0, 0, 0};
    full_check(a, w);
    a = '{128, 0, 0, 0}; w = '{128, 0, 0, 0};
    full_check(a, w);

    // sweep of the operand space
    for (int x = 0; x < 256; x += 17) begin
      for (int y = 0; y < 256; y += 17) begin
        a = '{x, y, 255 - x, x};
        w = '{y, x, y, 255 - y};
        full_check(a, w);
      end
    end

    // R8: start and operand changes during a run are ignored
    a = '{90, 30, 200, 5}; w = '{60, 250, 13, 128};
    fork
      run(a, w, res);
      begin
        repeat (60) @(negedge clk);
        act_i = '1; wgt_i = '1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
    join
    held = 0;
    for (int k = 0; k < LANES; k++) held += lane_ref(a[k], w[k]);
    check("R8 start ignored", res, held);

    // R7: the count holds while the inputs change without a start
    act_i = '0; wgt_i = '0;
    repeat (20) @(negedge clk);
    check("R7 count held", int'(count_o), held);
    check("R7 idle", int'(busy_o), 0);

    // R7: an accepted start clears the count
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 cleared on start", int'(count_o), 0);
    check("R6 busy after start", int'(busy_o), 1);
    while (busy_o) @(negedge clk);
    @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule